// File: doc/BRIEF.md
# Stealable Work-Range Sequencer

This block drives an accelerator across a half-open range of vertex indices, one cache line of eight vertex records at a time. Two host-visible registers hold the live range: a position register (the index of the next line to issue) and a limit register (the exclusive upper bound). A third register holds a progress allowance. This allowance is an estimate of how far the accelerator moves on while a host thread waits for a register read to return. A host loads the range while the block is idle and pulses `go`. The block then offers line requests with a valid/ready handshake until the position meets the limit, and then pulses `done`.

While the sequencer runs, another agent can take the upper part of the remaining range without pausing issue. It can do this in one of two ways. It can write a smaller limit through the register port. It can also pulse `steal_req`, in which case the block computes a line-aligned split point that skips the lines likely already issued, shrinks its own limit to that point, and returns the range it gave up. If too little work would remain beyond the allowance, the steal is refused and nothing changes.

Top module: `wr_range_seq`

## Requirements
- R1: After reset, all three registers read 0, and `req_valid`, `done`, `steal_ack` and `steal_ok` are low.
- R2: Register addresses are 0 = position, 1 = limit, 2 = allowance. While idle, a write to position or limit stores the value with its low 3 bits cleared. The allowance is stored unaligned and can be written at any time.
- R3: While busy and position < limit, `req_valid` is high with `req_idx` equal to the position, and both hold until `req_ready` is seen. The position advances by 8 only on a cycle in which `req_valid` and `req_ready` are both high.
- R4: When busy and position >= limit, the block goes idle and `done` is high for exactly one cycle, on the cycle after the last accepted line.
- R5: A steal request made while busy computes split = ((position + allowance + limit) / 2) with the low 3 bits cleared. If the steal is accepted, then one cycle later `steal_ack` and `steal_ok` are high, `steal_lo` = split, `steal_hi` = the old limit, and the limit register reads split.
- R6: A steal is refused (`steal_ack` high, `steal_ok` low, `steal_lo` = `steal_hi` = limit, limit unchanged) when split <= (position + allowance) rounded up to a multiple of 8, when split >= limit, or when the block is idle.
- R7: While busy, a limit write below the current limit takes effect with its low 3 bits cleared. The new limit is never lower than position + 8 while a line is being offered.
- R8: While busy, a limit write at or above the current limit is ignored, and so is any write to position.
- R9: When a steal request and a limit write arrive in the same cycle while busy, the steal is served and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Begin walking the loaded range (ignored while busy) |
| done | output | 1 | One-cycle pulse when the range is exhausted |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 position, 1 limit, 2 allowance |
| reg_wdata | input | IDX_W | Register write data |
| reg_rdata | output | IDX_W | Read data for `reg_addr` (combinational) |
| steal_req | input | 1 | Request a hardware-computed split |
| steal_ack | output | 1 | Steal response valid, one cycle after the request |
| steal_ok | output | 1 | Steal accepted |
| steal_lo | output | IDX_W | First index handed over |
| steal_hi | output | IDX_W | Exclusive end of the handed-over range |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Line request accepted by the consumer |
| req_idx | output | IDX_W | First vertex index of the requested line |

## Verification
The assertions check every cycle that the position and limit stay line-aligned, that an offered line holds still under backpressure, that the position moves only by one line per handshake, and that the limit never rises during a run. They also check that no cut leaves the limit below the line in flight and that an accepted steal hands back a non-empty aligned range that matches the new limit. Only the bench scenarios can show the actual split arithmetic: the rejection on the equality boundary, the order of lines under irregular ready patterns, the exact cycle of `done`, and which of two colliding requests wins.

// File: rtl/wr_range_pkg.sv
package wr_range_pkg;
    typedef enum logic [1:0] {
        RA_POS   = 2'd0,
        RA_LIMIT = 2'd1,
        RA_LEAD  = 2'd2,
        RA_RSVD  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/wr_split_calc.sv
module wr_split_calc #(
    parameter int IDX_W   = 32,
    parameter int LINE_LG = 3
) (
    input  logic             busy,
    input  logic [IDX_W-1:0] pos,
    input  logic [IDX_W-1:0] limit,
    input  logic [IDX_W-1:0] lead,
    output logic [IDX_W-1:0] split,
    output logic             accept
);
    localparam int W = IDX_W + 2;
    localparam logic [W-1:0] LMASK = W'((1 << LINE_LG) - 1);

    logic [W-1:0] guard_raw;
    logic [W-1:0] guard_up;
    logic [W-1:0] total;
    logic [W-1:0] cut;

    always_comb begin
        guard_raw = W'(pos) + W'(lead);
        guard_up  = (guard_raw + LMASK) & ~LMASK;
        total     = guard_raw + W'(limit);
        cut       = (total >> 1) & ~LMASK;
        accept    = busy && (cut > guard_up) && (cut < W'(limit));
        split     = accept ? cut[IDX_W-1:0] : limit;
    end
endmodule

// File: rtl/wr_limit_clamp.sv
module wr_limit_clamp #(
    parameter int IDX_W   = 32,
    parameter int LINE_LG = 3
) (
    input  logic [IDX_W-1:0] wdata,
    input  logic [IDX_W-1:0] pos,
    input  logic [IDX_W-1:0] limit,
    input  logic             line_live,
    output logic             take,
    output logic [IDX_W-1:0] new_limit
);
    localparam logic [IDX_W-1:0] LMASK = IDX_W'((1 << LINE_LG) - 1);
    localparam logic [IDX_W-1:0] STEP  = IDX_W'(1 << LINE_LG);

    logic [IDX_W-1:0] wa;
    logic [IDX_W-1:0] floor_v;

    always_comb begin
        wa        = wdata & ~LMASK;
        floor_v   = line_live ? pos + STEP : pos;
        take      = wa < limit;
        new_limit = (wa < floor_v) ? floor_v : wa;
    end
endmodule

// File: rtl/wr_range_seq.sv
module wr_range_seq
    import wr_range_pkg::*;
#(
    parameter int IDX_W      = 32,
    parameter int LINE_VERTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output logic             done,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [IDX_W-1:0] reg_wdata,
    output logic [IDX_W-1:0] reg_rdata,
    input  logic             steal_req,
    output logic             steal_ack,
    output logic             steal_ok,
    output logic [IDX_W-1:0] steal_lo,
    output logic [IDX_W-1:0] steal_hi,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [IDX_W-1:0] req_idx
);
    localparam int LINE_LG = $clog2(LINE_VERTS);
    localparam logic [IDX_W-1:0] LMASK = IDX_W'(LINE_VERTS - 1);
    localparam logic [IDX_W-1:0] STEP  = IDX_W'(LINE_VERTS);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] pos;
        logic [IDX_W-1:0] limit;
        logic [IDX_W-1:0] lead;
        logic             ack;
        logic             ok;
        logic [IDX_W-1:0] lo;
        logic [IDX_W-1:0] hi;
    } state_t;

    state_t st_d, st_q;

    logic             busy_q;
    logic [IDX_W-1:0] pos_q;
    logic [IDX_W-1:0] limit_q;
    logic [IDX_W-1:0] split_pt;
    logic             split_ok;
    logic             clamp_take;
    logic [IDX_W-1:0] clamp_val;
    logic             line_live;
    reg_addr_e        ra;

    assign busy_q    = st_q.busy;
    assign pos_q     = st_q.pos;
    assign limit_q   = st_q.limit;
    assign line_live = st_q.busy && (st_q.pos < st_q.limit);
    assign ra        = reg_addr_e'(reg_addr);

    wr_split_calc #(.IDX_W(IDX_W), .LINE_LG(LINE_LG)) u_split (
        .busy  (st_q.busy),
        .pos   (st_q.pos),
        .limit (st_q.limit),
        .lead  (st_q.lead),
        .split (split_pt),
        .accept(split_ok)
    );

    wr_limit_clamp #(.IDX_W(IDX_W), .LINE_LG(LINE_LG)) u_clamp (
        .wdata    (reg_wdata),
        .pos      (st_q.pos),
        .limit    (st_q.limit),
        .line_live(line_live),
        .take     (clamp_take),
        .new_limit(clamp_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.ack  = 1'b0;

        if (line_live && req_ready) begin
            st_d.pos = st_q.pos + STEP;
        end

        if (reg_wr && ra == RA_LEAD) begin
            st_d.lead = reg_wdata;
        end

        if (!st_q.busy) begin
            if (reg_wr && ra == RA_POS) begin
                st_d.pos = reg_wdata & ~LMASK;
            end
            if (reg_wr && ra == RA_LIMIT) begin
                st_d.limit = reg_wdata & ~LMASK;
            end
            if (go) begin
                st_d.busy = 1'b1;
            end
        end

        if (steal_req) begin
            st_d.ack = 1'b1;
            st_d.ok  = split_ok;
            st_d.lo  = split_pt;
            st_d.hi  = st_q.limit;
            if (split_ok) begin
                st_d.limit = split_pt;
            end
        end else if (st_q.busy && reg_wr && ra == RA_LIMIT && clamp_take) begin
            st_d.limit = clamp_val;
        end

        if (st_q.busy && (st_q.pos >= st_q.limit)) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (ra)
            RA_POS:   reg_rdata = st_q.pos;
            RA_LIMIT: reg_rdata = st_q.limit;
            RA_LEAD:  reg_rdata = st_q.lead;
            default:  reg_rdata = '0;
        endcase
    end

    assign done      = st_q.done;
    assign steal_ack = st_q.ack;
    assign steal_ok  = st_q.ack && st_q.ok;
    assign steal_lo  = st_q.lo;
    assign steal_hi  = st_q.hi;
    assign req_valid = line_live;
    assign req_idx   = st_q.pos;
endmodule

// File: rtl/wr_range_seq_chk.sv
module wr_range_seq_chk #(
    parameter int IDX_W   = 32,
    parameter int LINE_LG = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_q,
    input logic [IDX_W-1:0] pos_q,
    input logic [IDX_W-1:0] limit_q,
    input logic             done,
    input logic             steal_ack,
    input logic             steal_ok,
    input logic [IDX_W-1:0] steal_lo,
    input logic [IDX_W-1:0] steal_hi,
    input logic             req_valid,
    input logic             req_ready,
    input logic [IDX_W-1:0] req_idx
);
    localparam logic [IDX_W-1:0] STEP = IDX_W'(1 << LINE_LG);

    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q[LINE_LG-1:0] == '0) && (limit_q[LINE_LG-1:0] == '0));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_idx));

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> pos_q == $past(pos_q) + STEP);

    a_r3_still: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !(req_valid && req_ready) |=> pos_q == $past(pos_q));

    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy_q && !req_valid);

    a_r5_grant_shape: assert property (@(posedge clk) disable iff (!rst_n)
        steal_ack && steal_ok |-> (steal_lo == limit_q) && (steal_lo < steal_hi)
            && (steal_lo[LINE_LG-1:0] == '0));

    a_r6_refuse_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_q) && steal_ack && !steal_ok |-> $stable(limit_q));

    a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && req_valid |=> limit_q >= $past(pos_q) + STEP);

    a_r8_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> limit_q <= $past(limit_q));
endmodule

bind wr_range_seq wr_range_seq_chk #(.IDX_W(IDX_W), .LINE_LG(LINE_LG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_q   (busy_q),
    .pos_q    (pos_q),
    .limit_q  (limit_q),
    .done     (done),
    .steal_ack(steal_ack),
    .steal_ok (steal_ok),
    .steal_lo (steal_lo),
    .steal_hi (steal_hi),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_idx  (req_idx)
);

// File: tb/wr_range_seq_tb.sv
module wr_range_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        done;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        steal_req = 1'b0;
    logic        steal_ack, steal_ok;
    logic [31:0] steal_lo, steal_hi;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_idx;

    int n_chk = 0;
    int n_fail = 0;
    int unsigned exp_q[$];

    always #5 clk = ~clk;

    wr_range_seq u_dut (
        .clk(clk), .rst_n(rst_n), .go(go), .done(done),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .steal_req(steal_req), .steal_ack(steal_ack), .steal_ok(steal_ok),
        .steal_lo(steal_lo), .steal_hi(steal_hi),
        .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each accepted line
    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3 unexpected line: actual %0d expected none", req_idx);
            end else begin
                int unsigned e;
                e = exp_q.pop_front();
                if (req_idx != e) begin
                    n_fail++;
                    $display("FAIL R3 line order: actual %0d expected %0d", req_idx, e);
                end
            end
        end
    end

    task automatic push_lines(input int unsigned lo, input int unsigned hi);
        for (int unsigned a = lo; a < hi; a += 8) exp_q.push_back(a);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a; #1;
        v = reg_rdata;
    endtask

    task automatic kick;
        @(posedge clk); #1; go = 1'b1;
        @(posedge clk); #1; go = 1'b0;
    endtask

    task automatic steal(input logic with_wr, input logic [31:0] wd);
        @(posedge clk); #1;
        steal_req = 1'b1;
        if (with_wr) begin reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = wd; end
        @(posedge clk); #1;
        steal_req = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(posedge clk); #1; cyc++;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int cyc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 pos", v, 0);
        rd(2'd1, v); chk("R1 limit", v, 0);
        rd(2'd2, v); chk("R1 lead", v, 0);
        chk("R1 valid", req_valid, 0);
        chk("R1 done", done, 0);
        chk("R1 ack", steal_ack, 0);

        // R2 aligned idle writes, unaligned allowance
        wr(2'd0, 32'd5);  rd(2'd0, v); chk("R2 pos align", v, 0);
        wr(2'd1, 32'd21); rd(2'd1, v); chk("R2 limit align", v, 16);
        wr(2'd2, 32'd13); rd(2'd2, v); chk("R2 lead raw", v, 13);

        // R6 steal while idle is refused
        steal(1'b0, 0);
        chk("R6 idle ack", steal_ack, 1);
        chk("R6 idle ok", steal_ok, 0);

        // R3/R4 full run with constant ready, done timing
        wr(2'd1, 32'd64);
        req_ready = 1'b1;
        push_lines(0, 64);
        kick();
        wait_done(cyc);
        chk("R4 done cycle", cyc, 9);
        @(posedge clk); #1;
        chk("R4 done pulse", done, 0);
        chk("R3 queue drained", exp_q.size(), 0);

        // R5/R6 steals under stall
        req_ready = 1'b0;
        wr(2'd0, 32'd0); wr(2'd1, 32'd256); wr(2'd2, 32'd16);
        kick();
        chk("R3 valid stalled", req_valid, 1);
        chk("R3 idx stalled", req_idx, 0);
        steal(1'b0, 0);
        chk("R5 ok1", steal_ok, 1); chk("R5 lo1", steal_lo, 136); chk("R5 hi1", steal_hi, 256);
        rd(2'd1, v); chk("R5 limit1", v, 136);
        steal(1'b0, 0);
        chk("R5 ok2", steal_ok, 1); chk("R5 lo2", steal_lo, 72); chk("R5 hi2", steal_hi, 136);
        wr(2'd2, 32'd64);
        steal(1'b0, 0);
        chk("R6 equal guard ack", steal_ack, 1);
        chk("R6 equal guard ok", steal_ok, 0);
        rd(2'd1, v); chk("R6 limit kept", v, 72);
        wr(2'd2, 32'd120);
        steal(1'b0, 0);
        chk("R6 above limit ok", steal_ok, 0);
        rd(2'd1, v); chk("R6 limit kept2", v, 72);
        push_lines(0, 72);
        req_ready = 1'b1;
        wait_done(cyc);
        chk("R4 done after steals", done, 1);
        chk("R3 queue drained2", exp_q.size(), 0);

        // R9 steal beats concurrent write; R7/R8 busy writes
        req_ready = 1'b0;
        wr(2'd0, 32'd0); wr(2'd1, 32'd256); wr(2'd2, 32'd0);
        kick();
        steal(1'b1, 32'd40);
        chk("R9 ok", steal_ok, 1); chk("R9 lo", steal_lo, 128);
        rd(2'd1, v); chk("R9 limit", v, 128);
        wr(2'd1, 32'd45);  rd(2'd1, v); chk("R7 lower write", v, 40);
        wr(2'd1, 32'd200); rd(2'd1, v); chk("R8 higher ignored", v, 40);
        wr(2'd0, 32'd100); rd(2'd0, v); chk("R8 pos ignored", v, 0);
        wr(2'd1, 32'd3);   rd(2'd1, v); chk("R7 floor", v, 8);
        push_lines(0, 8);
        req_ready = 1'b1;
        wait_done(cyc);
        chk("R4 done after cut", done, 1);
        chk("R7 queue drained", exp_q.size(), 0);

        // R3 irregular backpressure
        req_ready = 1'b0;
        wr(2'd0, 32'd64); wr(2'd1, 32'd160);
        push_lines(64, 160);
        kick();
        cyc = 0;
        while (!done && cyc < 2000) begin
            req_ready = (cyc % 3) != 0;
            @(posedge clk); #1; cyc++;
        end
        chk("R4 done irregular", done, 1);
        chk("R3 queue drained3", exp_q.size(), 0);
        rd(2'd0, v); chk("R3 final pos", v, 160);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule